// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interpreter of one NOR-style flash bank. It watches bus write cycles, each an address and a data byte, and recognises multi-cycle command sequences. Two of them start an abstracted internal erase: erasing the whole chip, or erasing a set of sectors. A countdown stands in for the real erase time. Sector erase first opens a timeout window. While that window is open, more sectors can be added before the erase starts.

A shortened command mode, entered by a command or by holding an accelerate pin, lets chip erase and word program be issued in two writes. A two-write exit sequence leaves it. While the bank erases, all writes are ignored. A hardware reset returns the bank to read mode from any state, in the next cycle. Command bytes are compared on `wr_data[7:0]`. Unlock addresses are compared on `wr_addr[10:0]`. The sector number is `wr_addr[ADDR_W-1 -: log2(NUM_SECT)]`, which is `wr_addr[11:8]` by default.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and in the cycle after any clock edge that samples `rst_n` low (including one in the middle of an erase), `read_mode`=1, `busy`=0, `chip_erase_req`=0 and `sector_sel`=0.
- R2: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 (data@address, hex) start a chip erase. `busy` and `chip_erase_req` are high from the cycle after the sixth write, for exactly ERASE_CYCLES cycles, and `sector_sel` stays 0.
- R3: The same five leading writes followed by 30h at any address open the sector window. From the next cycle, `sector_sel` has the bit of that address's sector set, and `read_mode`=0 and `busy`=0.
- R4: Inside the window, each further write of 30h adds its sector bit, in any sector order, and restarts the window. The window closes WINDOW_CYCLES cycles after the last accepted write. The erase then runs for ERASE_CYCLES cycles with `busy`=1, `chip_erase_req`=0 and `sector_sel` held.
- R5: A write inside the window whose data is not 30h cancels the pending erase. From the next cycle `sector_sel`=0 and `read_mode`=1, and no erase follows.
- R6: From read mode, a write that is not the expected next cycle of a sequence drops the partial sequence. Nothing is started and `read_mode` stays 1.
- R7: While an erase runs, every write is ignored: `busy` lasts ERASE_CYCLES cycles regardless, and `sector_sel` does not change.
- R8: When an erase completes, the bank is back in read mode in the next cycle: `read_mode`=1, `busy`=0, `sector_sel`=0. This holds even if the erase was started from the shortened mode.
- R9: AA@555, 55@2AA, 20@555 enters the shortened mode (`read_mode`=0, `busy`=0). In that mode, 80h then 10h at any address starts a chip erase as in R2.
- R10: In the shortened mode, 90h then 00h at any address returns to read mode. A write that matches no shortened command leaves the bank in the shortened mode.
- R11: While the bank is in read mode with no partial sequence, `accel`=1 at a clock edge puts it in the shortened mode from the next cycle.
- R12: In the shortened mode, A0h followed by any one write (the program word) completes a program. The bank stays in the shortened mode with `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, sampled on the clock |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Command byte of the write |
| accel | input | 1 | Accelerate pin, forces the shortened mode from read mode |
| busy | output | 1 | Internal erase running |
| read_mode | output | 1 | Bank is in read mode (possibly mid-sequence) |
| sector_sel | output | NUM_SECT | Sectors queued or being erased |
| chip_erase_req | output | 1 | The running erase covers the whole chip |

## Verification
All outputs come straight from registers. Each write therefore shows its effect in the cycle after the edge that samples it. Window expiry is due WINDOW_CYCLES edges after the last accepted sector write, and the erase ends ERASE_CYCLES edges after it starts. The bench keeps a behavioural model that advances on the same edge the design samples. It compares all four outputs at the following falling edge, and it counts consecutive busy cycles to check the exact erase length.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_SETUP, ST_E1, ST_E2,
    ST_WINDOW, ST_ERASE,
    ST_BYP, ST_BYP_ERS, ST_BYP_PRG, ST_BYP_EXIT
  } seq_state_t;

  localparam logic [10:0] ADR_A = 11'h555;
  localparam logic [10:0] ADR_B = 11'h2AA;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_EXIT1   = 8'h90;
  localparam logic [7:0] CMD_EXIT2   = 8'h00;

  function automatic logic bus_hit(input logic [10:0] a, input logic [7:0] d,
                                   input logic [10:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic in_read_mode(input seq_state_t s);
    return (s == ST_READ) || (s == ST_U1) || (s == ST_U2) ||
           (s == ST_SETUP) || (s == ST_E1) || (s == ST_E2);
  endfunction

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int TMR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= load_val;
    else if (run && cnt != '0)     cnt <= cnt - TMR_W'(1);
  end

  assign done = run && (cnt == '0);

  // R4: a load sets the countdown to the requested length
  a_r4_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R2: a running, non-zero countdown steps down by one
  a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> cnt == $past(cnt) - TMR_W'(1));
endmodule

// File: rtl/flash_sector_set.sv
module flash_sector_set #(
  parameter int NUM_SECT = 16,
  localparam int SECT_W = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add,
  input  logic [SECT_W-1:0]   add_idx,
  input  logic                clr,
  output logic [NUM_SECT-1:0] bits
);
  for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                       bits[i] <= 1'b0;
      else if (add && add_idx == SECT_W'(i))   bits[i] <= 1'b1;
    end
  end

  // R4: without a clear, queued sectors are never dropped
  a_r4_set_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (bits & $past(bits)) == $past(bits));
  // R5: a clear empties the set
  a_r5_set_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> bits == '0);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [10:0] lo_addr,
  input  logic [7:0]  wr_data,
  input  logic        accel,
  input  logic        tmr_done,
  output seq_state_t  state,
  output logic        ev_chip_cmd,
  output logic        ev_sector_cmd,
  output logic        ev_window_expire,
  output logic        ev_window_abort,
  output logic        ev_erase_done,
  output logic        chip_q
);
  seq_state_t nxt;

  assign ev_sector_cmd    = wr_en && wr_data == CMD_SECTOR &&
                            (state == ST_E2 || state == ST_WINDOW);
  assign ev_chip_cmd      = wr_en &&
                            ((state == ST_E2 && bus_hit(lo_addr, wr_data, ADR_A, CMD_CHIP)) ||
                             (state == ST_BYP_ERS && wr_data == CMD_CHIP));
  assign ev_window_expire = state == ST_WINDOW && !wr_en && tmr_done;
  assign ev_window_abort  = state == ST_WINDOW && wr_en && wr_data != CMD_SECTOR;
  assign ev_erase_done    = state == ST_ERASE && tmr_done;

  always_comb begin
    nxt = state;
    case (state)
      ST_READ:
        if (accel) nxt = ST_BYP;
        else if (wr_en) nxt = bus_hit(lo_addr, wr_data, ADR_A, CMD_KEY1) ? ST_U1 : ST_READ;
      ST_U1:
        if (wr_en) nxt = bus_hit(lo_addr, wr_data, ADR_B, CMD_KEY2) ? ST_U2 : ST_READ;
      ST_U2:
        if (wr_en) begin
          if (bus_hit(lo_addr, wr_data, ADR_A, CMD_SETUP))       nxt = ST_SETUP;
          else if (bus_hit(lo_addr, wr_data, ADR_A, CMD_BYPASS)) nxt = ST_BYP;
          else                                                   nxt = ST_READ;
        end
      ST_SETUP:
        if (wr_en) nxt = bus_hit(lo_addr, wr_data, ADR_A, CMD_KEY1) ? ST_E1 : ST_READ;
      ST_E1:
        if (wr_en) nxt = bus_hit(lo_addr, wr_data, ADR_B, CMD_KEY2) ? ST_E2 : ST_READ;
      ST_E2:
        if (wr_en) nxt = ev_chip_cmd ? ST_ERASE : (ev_sector_cmd ? ST_WINDOW : ST_READ);
      ST_WINDOW:
        if (wr_en) nxt = ev_sector_cmd ? ST_WINDOW : ST_READ;
        else if (tmr_done) nxt = ST_ERASE;
      ST_ERASE:
        if (tmr_done) nxt = ST_READ;
      ST_BYP:
        if (wr_en) begin
          case (wr_data)
            CMD_SETUP:   nxt = ST_BYP_ERS;
            CMD_PROGRAM: nxt = ST_BYP_PRG;
            CMD_EXIT1:   nxt = ST_BYP_EXIT;
            default:     nxt = ST_BYP;
          endcase
        end
      ST_BYP_ERS:
        if (wr_en) nxt = ev_chip_cmd ? ST_ERASE : ST_BYP;
      ST_BYP_PRG:
        if (wr_en) nxt = ST_BYP;
      ST_BYP_EXIT:
        if (wr_en) nxt = (wr_data == CMD_EXIT2) ? ST_READ : ST_BYP;
      default: nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_READ;
      chip_q <= 1'b0;
    end else begin
      state <= nxt;
      if (ev_chip_cmd)        chip_q <= 1'b1;
      else if (ev_erase_done) chip_q <= 1'b0;
    end
  end

  // R7: writes cannot end or alter a running erase
  a_r7_erase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && !tmr_done) |=> state == ST_ERASE);
  // R4: a quiet, expired window starts the erase
  a_r4_window_to_erase: assert property (@(posedge clk) disable iff (!rst_n)
    ev_window_expire |=> state == ST_ERASE);
  // R5: a foreign write in the window returns to read mode
  a_r5_abort_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_window_abort |=> state == ST_READ);
  // R11: accelerate pin from idle read mode enters the shortened mode
  a_r11_accel_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && accel) |=> state == ST_BYP);
  // R12: the program word returns to the shortened mode
  a_r12_prog_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BYP_PRG && wr_en) |=> state == ST_BYP);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int NUM_SECT      = 16,
  parameter int ERASE_CYCLES  = 20,
  parameter int WINDOW_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                accel,
  output logic                busy,
  output logic                read_mode,
  output logic [NUM_SECT-1:0] sector_sel,
  output logic                chip_erase_req
);
  localparam int SECT_W  = $clog2(NUM_SECT);
  localparam int MAX_CYC = (ERASE_CYCLES > WINDOW_CYCLES) ? ERASE_CYCLES : WINDOW_CYCLES;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  seq_state_t        state;
  logic              ev_chip_cmd, ev_sector_cmd, ev_window_expire;
  logic              ev_window_abort, ev_erase_done, chip_q, tmr_done;
  logic              tmr_load, tmr_run;
  logic [TMR_W-1:0]  tmr_val;
  logic [SECT_W-1:0] sect_idx;

  assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];

  flash_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lo_addr(wr_addr[10:0]),
    .wr_data(wr_data), .accel(accel), .tmr_done(tmr_done), .state(state),
    .ev_chip_cmd(ev_chip_cmd), .ev_sector_cmd(ev_sector_cmd),
    .ev_window_expire(ev_window_expire), .ev_window_abort(ev_window_abort),
    .ev_erase_done(ev_erase_done), .chip_q(chip_q)
  );

  assign tmr_load = ev_chip_cmd || ev_sector_cmd || ev_window_expire;
  assign tmr_val  = ev_sector_cmd ? TMR_W'(WINDOW_CYCLES - 1) : TMR_W'(ERASE_CYCLES - 1);
  assign tmr_run  = (state == ST_WINDOW) || (state == ST_ERASE);

  flash_op_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .done(tmr_done)
  );

  flash_sector_set #(.NUM_SECT(NUM_SECT)) u_set (
    .clk(clk), .rst_n(rst_n), .add(ev_sector_cmd), .add_idx(sect_idx),
    .clr(ev_window_abort || ev_erase_done), .bits(sector_sel)
  );

  assign busy           = (state == ST_ERASE);
  assign chip_erase_req = busy && chip_q;
  assign read_mode      = in_read_mode(state);

  // R8: a completed erase leaves the bank idle in read mode
  a_r8_done_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erase_done |=> (read_mode && !busy && sector_sel == '0));
  // R2: a chip erase start raises busy with the chip flag
  a_r2_chip_start: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chip_cmd |=> (busy && chip_erase_req && sector_sel == '0));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  localparam int ADDR_W = 12, NUM_SECT = 16, ERASE_CYCLES = 20, WINDOW_CYCLES = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, accel = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, read_mode, chip_erase_req;
  logic [NUM_SECT-1:0] sector_sel;

  int checks = 0, failures = 0, busy_len = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT),
    .ERASE_CYCLES(ERASE_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accel(accel), .busy(busy), .read_mode(read_mode), .sector_sel(sector_sel),
    .chip_erase_req(chip_erase_req));

  // ---------------- behavioural reference model ----------------
  int m_mode = 0;   // 0 read, 1 shortened
  int m_phase = 0;  // 0 none, 1 window, 2 erasing
  int m_left = 0;
  bit m_chip = 0;
  bit [NUM_SECT-1:0] m_set = '0;
  int qa[$], qd[$];

  function automatic int seq_len(int s);
    case (s) 0, 1: return 6; 2: return 3; default: return 2; endcase
  endfunction

  // expected (address, data) of cycle i of sequence s; -1 means any
  function automatic bit seq_ok(int s, int i, int a, int d);
    int ea, ed;
    ea = -1; ed = -1;
    if (s <= 2) begin
      case (i)
        0, 3: begin ea = 'h555; ed = 'hAA; end
        1, 4: begin ea = 'h2AA; ed = 'h55; end
        2: begin ea = 'h555; ed = (s == 2) ? 'h20 : 'h80; end
        default: begin ea = (s == 0) ? 'h555 : -1; ed = (s == 0) ? 'h10 : 'h30; end
      endcase
      if (s == 2 && i > 2) return 0;
    end else if (s == 3) ed = (i == 0) ? 'h80 : 'h10;
    else if (s == 4) ed = (i == 0) ? 'h90 : 'h00;
    else ed = (i == 0) ? 'hA0 : -1;
    return (ea < 0 || ea == (a & 'h7FF)) && (ed < 0 || ed == d);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_phase = 0; m_left = 0; m_chip = 0; m_set = '0;
      qa.delete(); qd.delete();
    end else if (m_phase == 2) begin
      m_left--;
      if (m_left == 0) begin m_phase = 0; m_mode = 0; m_chip = 0; m_set = '0; end
    end else if (m_phase == 1) begin
      if (wr_en) begin
        if (wr_data == 8'h30) begin m_set[wr_addr >> 8] = 1'b1; m_left = WINDOW_CYCLES; end
        else begin m_phase = 0; m_set = '0; end
      end else begin
        m_left--;
        if (m_left == 0) begin m_phase = 2; m_left = ERASE_CYCLES; end
      end
    end else if (m_mode == 0 && qa.size() == 0 && accel) begin
      m_mode = 1;
    end else if (wr_en) begin
      int full, pref;
      full = -1; pref = 0;
      qa.push_back(int'(wr_addr)); qd.push_back(int'(wr_data));
      for (int s = (m_mode == 0 ? 0 : 3); s <= (m_mode == 0 ? 2 : 5); s++) begin
        bit ok;
        ok = (qa.size() <= seq_len(s));
        for (int i = 0; i < qa.size() && ok; i++) ok = seq_ok(s, i, qa[i], qd[i]);
        if (ok && qa.size() == seq_len(s)) full = s;
        else if (ok) pref = 1;
      end
      if (full >= 0) begin
        qa.delete(); qd.delete();
        case (full)
          0, 3: begin m_phase = 2; m_left = ERASE_CYCLES; m_chip = 1; end
          1: begin m_phase = 1; m_left = WINDOW_CYCLES; m_set[wr_addr >> 8] = 1'b1; end
          2: m_mode = 1;
          4: m_mode = 0;
          default: ;
        endcase
      end else if (!pref) begin
        qa.delete(); qd.delete();
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (busy) busy_len++;
    if (cmp_on) begin
      bit exp_read, exp_busy, exp_chip;
      exp_read = (m_mode == 0 && m_phase == 0);
      exp_busy = (m_phase == 2);
      exp_chip = (m_phase == 2 && m_chip);
      checks++;
      if (read_mode !== exp_read || busy !== exp_busy ||
          chip_erase_req !== exp_chip || sector_sel !== m_set) begin
        failures++;
        $display("FAIL %s model: got rd=%b bsy=%b chip=%b sel=%h exp rd=%b bsy=%b chip=%b sel=%h",
                 tag, read_mode, busy, chip_erase_req, sector_sel,
                 exp_read, exp_busy, exp_chip, m_set);
      end
    end
  end

  task automatic check_eq(string r, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prefix5();
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80); wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(1);
    tag = "R1";
    check_eq("R1", "read_mode", read_mode, 1);
    check_eq("R1", "busy", busy, 0);
    check_eq("R1", "sector_sel", sector_sel, 0);

    // R2 chip erase
    tag = "R2";
    prefix5(); busy_len = 0; wr('h555, 'h10);
    check_eq("R2", "busy", busy, 1);
    check_eq("R2", "chip_erase_req", chip_erase_req, 1);
    idle(ERASE_CYCLES + 4);
    check_eq("R2", "busy length", busy_len, ERASE_CYCLES);
    check_eq("R8", "read_mode after erase", read_mode, 1);

    // R7 writes ignored during erase
    tag = "R7";
    prefix5(); busy_len = 0; wr('h555, 'h10);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h300, 'h30); wr('h000, 'h90); wr('h000, 'h00);
    check_eq("R7", "sector_sel during erase", sector_sel, 0);
    idle(ERASE_CYCLES);
    check_eq("R7", "busy length", busy_len, ERASE_CYCLES);

    // R3 / R4 sector erase with window
    tag = "R3";
    prefix5(); wr('h300, 'h30);
    check_eq("R3", "sector_sel", sector_sel, 'h0008);
    check_eq("R3", "read_mode", read_mode, 0);
    check_eq("R3", "busy", busy, 0);
    tag = "R4";
    wr('hE00, 'h30); wr('h900, 'h30);
    idle(3);
    check_eq("R4", "busy inside restarted window", busy, 0);
    check_eq("R4", "sector_sel", sector_sel, 'h4208);
    busy_len = 0;
    for (int k = 0; k < 20 && !busy; k++) @(negedge clk);
    check_eq("R4", "sector_sel while erasing", sector_sel, 'h4208);
    check_eq("R4", "chip_erase_req", chip_erase_req, 0);
    idle(ERASE_CYCLES + 2);
    check_eq("R4", "busy length", busy_len, ERASE_CYCLES);
    tag = "R8";
    check_eq("R8", "sector_sel cleared", sector_sel, 0);
    check_eq("R8", "read_mode", read_mode, 1);

    // R5 abort window
    tag = "R5";
    prefix5(); wr('h100, 'h30); wr('h555, 'h55);
    check_eq("R5", "sector_sel", sector_sel, 0);
    check_eq("R5", "read_mode", read_mode, 1);
    idle(WINDOW_CYCLES + 4);
    check_eq("R5", "busy", busy, 0);

    // R6 mismatch
    tag = "R6";
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h77);
    check_eq("R6", "read_mode", read_mode, 1);
    wr('h555, 'h10); wr('h554, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    idle(4);
    check_eq("R6", "busy", busy, 0);

    // R9 / R12 / R10 shortened mode
    tag = "R9";
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h20);
    check_eq("R9", "read_mode", read_mode, 0);
    tag = "R12";
    wr('h123, 'hA0); wr('h456, 'h3C);
    check_eq("R12", "busy", busy, 0);
    check_eq("R12", "read_mode", read_mode, 0);
    tag = "R10";
    wr('h000, 'h55);
    check_eq("R10", "still shortened", read_mode, 0);
    tag = "R9";
    busy_len = 0; wr('h000, 'h80); wr('h7FF, 'h10);
    check_eq("R9", "chip_erase_req", chip_erase_req, 1);
    idle(ERASE_CYCLES + 2);
    check_eq("R9", "busy length", busy_len, ERASE_CYCLES);
    check_eq("R8", "read_mode after shortened erase", read_mode, 1);

    // R11 accelerate pin
    tag = "R11";
    @(negedge clk); accel = 1'b1;
    @(negedge clk); accel = 1'b0;
    check_eq("R11", "read_mode", read_mode, 0);
    tag = "R10";
    wr('h200, 'h90); wr('h000, 'h00);
    check_eq("R10", "read_mode after exit", read_mode, 1);

    // R1 reset mid-erase
    tag = "R1";
    prefix5(); wr('h555, 'h10);
    idle(5);
    check_eq("R1", "busy before reset", busy, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "read_mode after reset", read_mode, 1);
    check_eq("R1", "chip_erase_req after reset", chip_erase_req, 0);
    idle(ERASE_CYCLES);

    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule